// File: doc/BRIEF.md
# Oversampling Serial Receiver with Line Errors

This block recovers asynchronous serial characters from a single receive line. It shares a sixteen-times-bit-rate tick strobe and the line format settings with the transmit side of the port. A falling edge on the idle line starts a frame. The receiver confirms the start bit half a bit later. It then samples each data bit, the optional parity bit and the first stop bit once, near the centre of that bit.

When the stop bit has been sampled, the assembled character moves into a holding register and the data-ready flag goes high. Errors found in the frame set sticky flags for overrun, parity, framing and break. A read strobe for the holding register clears data-ready. A separate status-read strobe clears the four error flags. The block has no receive queue and no interrupt logic; those sit around it.

Top module: `uart_rx_core`

## Requirements
- R1: After reset all outputs are 0 and the receiver waits in idle for a falling edge with the line high.
- R2: A high-to-low line transition starts a frame. The start bit is checked 8 ticks after the edge, the first data bit is sampled 24 ticks after the edge, and every later bit 16 ticks after the previous one. Data arrives LSB first.
- R3: Word length select 00, 01, 10 and 11 gives 5, 6, 7 and 8 data bits. The character is right-aligned in `rx_data_o` with the unused upper bits 0.
- R4: With parity enabled, one parity bit follows the data. Select 1 means even parity and 0 means odd parity. A mismatch sets `parity_err_o`.
- R5: A stop-bit sample of 0 sets `framing_err_o`.
- R6: A frame whose start, data, parity and stop samples are all 0 sets `break_o` and `framing_err_o` and loads 0 into the holding register.
- R7: `data_ready_o` rises the cycle after a character completes. It is cleared by a pulse on `rd_data_i` and by nothing else.
- R8: A character that completes while `data_ready_o` is still 1 sets `overrun_o` and overwrites the holding register.
- R9: A pulse on `rd_status_i` clears overrun, parity, framing and break flags and leaves `data_ready_o` and the data unchanged. Error flags are sticky until then.
- R10: If the line reads high at the start-bit check, the frame is dropped with no flag change, and the receiver returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe at 16x the bit rate |
| rxd_i | input | 1 | Serial receive line, idle high |
| wlen_i | input | 2 | Word length select (00=5 .. 11=8 bits) |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| rd_data_i | input | 1 | Holding register read strobe |
| rd_status_i | input | 1 | Status read strobe, clears error flags |
| rx_data_o | output | 8 | Received character, right-aligned |
| data_ready_o | output | 1 | New character available |
| overrun_o | output | 1 | Character lost to overwrite |
| parity_err_o | output | 1 | Parity mismatch seen |
| framing_err_o | output | 1 | Stop bit sampled as 0 |
| break_o | output | 1 | All-zero frame seen |

## Verification
The line passes two synchronizer flops and an edge register before the tick count starts, so the start check falls 8 ticks and a few clocks after the edge. Each later sample lands near the middle of its bit. The character and its flags register one clock after the tick that samples the stop bit. The bench holds every bit for exactly 16 ticks and sets the line idle for two ticks after the stop bit. It samples outputs only at that point, on the falling clock edge, so every check comes well after the registered result and before the next frame. Strobe effects are checked two clocks after the strobe.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], rxd_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign line_o = sync_q[STAGES-1];
  assign fall_o = prev_q & ~sync_q[STAGES-1];

  AST_FALL_LINE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> !line_o); // R2
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          line_i,
  input  logic          fall_i,
  input  logic [1:0]    wlen_i,
  input  logic          par_en_i,
  input  logic          par_even_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          brk_o
);
  localparam int unsigned CW    = $clog2(OSR);
  localparam int unsigned BW    = $clog2(DW + 1);
  localparam int unsigned MIN_W = DW - 3;
  localparam logic [CW-1:0] HALF_LAST = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(OSR - 1);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] shr_q;
  logic          par_acc_q;
  logic          zero_q;
  logic [BW-1:0] nbits;
  logic          sample;

  assign nbits  = BW'(MIN_W) + BW'(wlen_i);
  assign sample = tick_i && (cnt_q == ((state_q == ST_START) ? HALF_LAST : FULL_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bit_q     <= '0;
      shr_q     <= '0;
      par_acc_q <= 1'b0;
      zero_q    <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (fall_i) begin
        state_q   <= ST_START;
        cnt_q     <= '0;
        bit_q     <= '0;
        par_acc_q <= 1'b0;
        zero_q    <= 1'b1;
      end
    end else if (tick_i) begin
      if (sample) begin
        cnt_q <= '0;
        unique case (state_q)
          ST_START: state_q <= line_i ? ST_IDLE : ST_DATA;  // glitch reject
          ST_DATA: begin
            shr_q     <= {line_i, shr_q[DW-1:1]};
            par_acc_q <= par_acc_q ^ line_i;
            zero_q    <= zero_q & ~line_i;
            bit_q     <= bit_q + BW'(1);
            if (bit_q == nbits - BW'(1)) state_q <= par_en_i ? ST_PAR : ST_STOP;
          end
          ST_PAR: begin
            par_acc_q <= par_acc_q ^ line_i;
            zero_q    <= zero_q & ~line_i;
            state_q   <= ST_STOP;
          end
          default: state_q <= ST_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // result registers, loaded on the stop-bit sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      data_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
      brk_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (sample && state_q == ST_STOP) begin
        done_o <= 1'b1;
        data_o <= shr_q >> (BW'(DW) - nbits);
        perr_o <= par_en_i & (par_acc_q ^ ~par_even_i);
        ferr_o <= ~line_i;
        brk_o  <= zero_q & ~line_i;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_DONE_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(tick_i)); // R2
  AST_GLITCH_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && sample && line_i) |=> state_q == ST_IDLE && !done_o); // R10
  AST_BRK_WITH_FERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && brk_o) |-> ferr_o && data_o == '0); // R6
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [DW-1:0] data_i,
  input  logic          perr_i,
  input  logic          ferr_i,
  input  logic          brk_i,
  input  logic          rd_data_i,
  input  logic          rd_status_i,
  output logic [DW-1:0] buf_o,
  output logic          dr_o,
  output logic          ovr_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          brk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_o  <= '0;
      dr_o   <= 1'b0;
      ovr_o  <= 1'b0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
      brk_o  <= 1'b0;
    end else begin
      if (done_i) buf_o <= data_i;

      if (done_i)         dr_o <= 1'b1;
      else if (rd_data_i) dr_o <= 1'b0;

      // new error beats a same-cycle status read
      if (done_i && dr_o && !rd_data_i) ovr_o <= 1'b1;
      else if (rd_status_i)             ovr_o <= 1'b0;

      if (done_i && perr_i)  perr_o <= 1'b1;
      else if (rd_status_i)  perr_o <= 1'b0;

      if (done_i && ferr_i)  ferr_o <= 1'b1;
      else if (rd_status_i)  ferr_o <= 1'b0;

      if (done_i && brk_i)   brk_o <= 1'b1;
      else if (rd_status_i)  brk_o <= 1'b0;
    end
  end

  AST_DONE_SETS_DR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> dr_o && buf_o == $past(data_i)); // R7
  AST_RD_CLEARS_DR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !done_i) |=> !dr_o); // R7
  AST_OVR_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && dr_o && !rd_data_i) |=> ovr_o); // R8
  AST_STATUS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_status_i && !done_i) |=> !(ovr_o || perr_o || ferr_o || brk_o)); // R9
  AST_STATUS_KEEPS_DR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_status_i && !rd_data_i && !done_i) |=> $stable(dr_o) && $stable(buf_o)); // R9
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int unsigned OSR    = 16,
  parameter int unsigned DW     = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic [1:0]    wlen_i,
  input  logic          par_en_i,
  input  logic          par_even_i,
  input  logic          rd_data_i,
  input  logic          rd_status_i,
  output logic [DW-1:0] rx_data_o,
  output logic          data_ready_o,
  output logic          overrun_o,
  output logic          parity_err_o,
  output logic          framing_err_o,
  output logic          break_o
);
  logic          line;
  logic          fall;
  logic          done;
  logic [DW-1:0] data;
  logic          perr;
  logic          ferr;
  logic          brk;

  uart_rx_sync #(.STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rxd_i  (rxd_i),
    .line_o (line),
    .fall_o (fall)
  );

  uart_rx_fsm #(.OSR(OSR), .DW(DW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .line_i     (line),
    .fall_i     (fall),
    .wlen_i     (wlen_i),
    .par_en_i   (par_en_i),
    .par_even_i (par_even_i),
    .done_o     (done),
    .data_o     (data),
    .perr_o     (perr),
    .ferr_o     (ferr),
    .brk_o      (brk)
  );

  uart_rx_status #(.DW(DW)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done),
    .data_i      (data),
    .perr_i      (perr),
    .ferr_i      (ferr),
    .brk_i       (brk),
    .rd_data_i   (rd_data_i),
    .rd_status_i (rd_status_i),
    .buf_o       (rx_data_o),
    .dr_o        (data_ready_o),
    .ovr_o       (overrun_o),
    .perr_o      (parity_err_o),
    .ferr_o      (framing_err_o),
    .brk_o       (break_o)
  );

  AST_BRK_IMPLIES_FERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |-> framing_err_o); // R6
endmodule

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;
  localparam int TICK_DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] wlen = 2'b11;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       rd_data = 1'b0;
  logic       rd_status = 1'b0;
  logic [7:0] rx_data;
  logic       dr, ovr, perr, ferr, brk;
  int         div_q = 0;
  int         n_chk = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    div_q <= (div_q == TICK_DIV - 1) ? 0 : div_q + 1;
    tick  <= (div_q == TICK_DIV - 1);
  end

  uart_rx_core u_uart_rx_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd),
    .wlen_i(wlen), .par_en_i(par_en), .par_even_i(par_even),
    .rd_data_i(rd_data), .rd_status_i(rd_status),
    .rx_data_o(rx_data), .data_ready_o(dr), .overrun_o(ovr),
    .parity_err_o(perr), .framing_err_o(ferr), .break_o(brk)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic hold_ticks(input int n);
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  task automatic strobe_data();
    @(negedge clk) rd_data = 1'b1;
    @(negedge clk) rd_data = 1'b0;
    @(negedge clk);
  endtask

  task automatic strobe_status();
    @(negedge clk) rd_status = 1'b1;
    @(negedge clk) rd_status = 1'b0;
    @(negedge clk);
  endtask

  // nb data bits LSB first, optional parity (flip to corrupt), one stop bit
  task automatic send(input logic [7:0] d, input int nb, input bit pflip, input logic stopv);
    logic p;
    p = 1'b0;
    for (int i = 0; i < nb; i++) p ^= d[i];
    if (!par_even) p = ~p;
    p ^= pflip;
    @(negedge clk) rxd = 1'b0;
    hold_ticks(16);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      hold_ticks(16);
    end
    if (par_en) begin
      rxd = p;
      hold_ticks(16);
    end
    rxd = stopv;
    hold_ticks(16);
    rxd = 1'b1;
    hold_ticks(2);
  endtask

  task automatic t_reset();
    check("R1 data", rx_data, 0);
    check("R1 flags", {dr, ovr, perr, ferr, brk}, 0);
  endtask

  task automatic t_basic();
    wlen = 2'b11; par_en = 1'b0;
    send(8'h61, 8, 0, 1'b1);
    check("R2 data 61", rx_data, 8'h61);
    check("R7 ready set", dr, 1);
    check("R5 no framing", {ovr, perr, ferr, brk}, 0);
    strobe_data();
    check("R7 ready cleared", dr, 0);
    send(8'hA5, 8, 0, 1'b1);
    check("R2 data A5", rx_data, 8'hA5);
    strobe_data();
  endtask

  task automatic t_wlen();
    wlen = 2'b00;
    send(8'h15, 5, 0, 1'b1);
    check("R3 5-bit", rx_data, 8'h15);
    strobe_data();
    wlen = 2'b10;
    send(8'h5A, 7, 0, 1'b1);
    check("R3 7-bit", rx_data, 8'h5A);
    strobe_data();
    wlen = 2'b01;
    send(8'h3F, 6, 0, 1'b1);
    check("R3 6-bit", rx_data, 8'h3F);
    check("R3 no errors", {ovr, perr, ferr, brk}, 0);
    strobe_data();
    wlen = 2'b11;
  endtask

  task automatic t_parity();
    par_en = 1'b1; par_even = 1'b1;
    send(8'hC3, 8, 0, 1'b1);
    check("R4 even ok", {rx_data, perr}, {8'hC3, 1'b0});
    strobe_data();
    par_even = 1'b0;
    send(8'h07, 8, 0, 1'b1);
    check("R4 odd ok", {rx_data, perr}, {8'h07, 1'b0});
    strobe_data();
    send(8'h07, 8, 1, 1'b1);
    check("R4 odd bad", perr, 1);
    strobe_data();
    send(8'h22, 8, 0, 1'b1);
    check("R9 sticky parity", perr, 1);
    strobe_status();
    check("R9 parity cleared", perr, 0);
    check("R9 ready kept", {dr, rx_data}, {1'b1, 8'h22});
    strobe_data();
    par_en = 1'b0;
  endtask

  task automatic t_overrun();
    send(8'h11, 8, 0, 1'b1);
    check("R8 no overrun yet", ovr, 0);
    send(8'h99, 8, 0, 1'b1);
    check("R8 overrun", ovr, 1);
    check("R8 overwrite", rx_data, 8'h99);
    strobe_status();
    check("R9 overrun cleared", {ovr, dr}, {1'b0, 1'b1});
    strobe_data();
  endtask

  task automatic t_framing();
    send(8'h5C, 8, 0, 1'b0);
    check("R5 framing", {ferr, brk}, 2'b10);
    check("R5 data kept", rx_data, 8'h5C);
    strobe_status();
    strobe_data();
    check("R5 cleared", {ferr, dr}, 0);
  endtask

  task automatic t_break();
    send(8'h00, 8, 0, 1'b0);
    check("R6 break", {brk, ferr}, 2'b11);
    check("R6 zero data", {rx_data, dr}, {8'h00, 1'b1});
    strobe_status();
    check("R9 break cleared", {brk, ferr}, 0);
    strobe_data();
  endtask

  task automatic t_glitch();
    @(negedge clk) rxd = 1'b0;
    hold_ticks(3);
    rxd = 1'b1;
    hold_ticks(200);
    check("R10 glitch ignored", {dr, ovr, perr, ferr, brk}, 0);
    send(8'h3C, 8, 0, 1'b1);
    check("R10 recovers", {rx_data, dr}, {8'h3C, 1'b1});
    strobe_data();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    hold_ticks(4);
    t_reset();
    t_basic();
    t_wlen();
    t_parity();
    t_overrun();
    t_framing();
    t_break();
    t_glitch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule